// File: doc/BRIEF.md
# Dual-chip parallel NOR flash command controller

This block models the command side of a 32-bit flash bank made from two 16-bit parallel NOR chips that receive every command together. A host on a plain memory-mapped bus (word offset, write strobe, read strobe, 32-bit data) writes command words to move the bank between its read modes. It can also start a block erase or a buffered multi-word program. The block keeps a status byte, a 32-word staging buffer and an internal storage array whose size is a parameter. The array powers up fully erased.

Reads return one of three things, chosen by the last command: array contents, the status byte copied into both chip halves, or an all-zero identifier. Erase and the final buffer-to-array copy run in a small sequencer that writes one 32-bit word per clock. While it runs, the bank reports itself not ready and ignores the bus.

Misuse ends the current sequence, raises a one-cycle error pulse and sets a sticky status flag. Misuse covers an unknown command, halves that disagree, a word count too large for the buffer, a stray data offset and a missing confirm.

Top module: `dual_nor_cmd_ctrl`

## Requirements
- R1: After reset the bank is in array-read mode, no command sequence is pending, and the status byte is 0x80 (bit 7 = ready, all other bits clear).
- R2: A read returns its data on `bus_rdata` one clock after the read strobe. In array-read mode, a never-programmed word reads 0xFFFFFFFF, and so does any word offset at or above the array size.
- R3: A first-cycle command word whose bits 31:16 differ from bits 15:0 is rejected as illegal.
- R4: Code 0x70 selects status-read mode, 0xFF selects array-read mode and 0x90 selects identifier mode, where every read returns 0x00000000. None of the three starts a multi-cycle sequence.
- R5: A status read returns the status byte in bits 7:0 and again in bits 23:16, with bits 31:24 and 15:8 zero.
- R6: Code 0x20 followed by a write at word offset A erases the words from A through A+BLOCK_WORDS-1, stopping at the last array word. Those words become 0xFFFFFFFF and neighbouring words keep their values. The bank then enters status-read mode.
- R7: The sequencer writes one word per clock. For an erase or copy of L words, status bit 7 reads 0 for exactly L clocks after the accepting write, and reads return status during that time.
- R8: Bus writes that arrive while the sequencer is running have no effect.
- R9: Code 0xE8 at offset T latches T as the target. The next write gives N-1 in bits 15:0, and N may be at most 32. The next N writes store data at buffer slot (offset − T). A following write of 0x00D0 copies buffer slots 0..N-1 to words T..T+N-1 and returns the bank to array-read mode.
- R10: If T+N exceeds the array size, the confirm leaves the array unchanged, raises no error and returns the bank to array-read mode.
- R11: From the 0xE8 write until the sequence ends, reads return status regardless of the read mode.
- R12: Each of the following raises `flash_err` for one clock, sets status bit 4 and returns the bank to array-read mode with no sequence pending: an unknown first-cycle code, N > 32, a data offset outside T..T+31, or a non-0xD0 write where the confirm is due.
- R13: Code 0x50 clears status bits 1, 3, 4 and 5 and selects array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_rd | input | 1 | Read strobe; data appears the next clock |
| bus_addr | input | ADDR_W | Word offset (one bit wider than the array index) |
| bus_wdata | input | 32 | Write data or command word |
| bus_rdata | output | 32 | Registered read data |
| flash_err | output | 1 | One-clock pulse on a rejected write |

## Verification
The hardest case to reach from the ports is the exact last clock of a running erase. A write arriving then must still be ignored, and the status must still show busy. The bench counts clocks from the accepting address write and issues a status read on the final busy clock, then another read one clock later. A bus command is slipped in just after the erase starts. Its effect on the read mode would show in the second read. A second hard case is the clipped erase at the array's end. Writes just above the array are also accepted into the buffer without being copied.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        PH_CMD        = 2'd0,
        PH_ERASE_ADDR = 2'd1,
        PH_PGM_COUNT  = 2'd2,
        PH_PGM_DATA   = 2'd3
    } phase_e;

    typedef enum logic {
        JOB_ERASE = 1'b0,
        JOB_COPY  = 1'b1
    } job_e;

    localparam logic [15:0] OP_ERASE_SETUP = 16'h0020;
    localparam logic [15:0] OP_CLR_STATUS  = 16'h0050;
    localparam logic [15:0] OP_RD_STATUS   = 16'h0070;
    localparam logic [15:0] OP_RD_IDENT    = 16'h0090;
    localparam logic [15:0] OP_PGM_SETUP   = 16'h00E8;
    localparam logic [15:0] OP_PGM_CONFIRM = 16'h00D0;
    localparam logic [15:0] OP_RD_ARRAY    = 16'h00FF;

    localparam logic [6:0] ST_CLR_MASK = 7'h3A;
    localparam int         ST_ERR_BIT  = 4;

    function automatic logic halves_match(input logic [31:0] w);
        return w[31:16] == w[15:0];
    endfunction

    function automatic logic [31:0] status_word(input logic [7:0] s);
        return {8'h00, s, 8'h00, s};
    endfunction

endpackage

// File: rtl/flcmd_array.sv
module flcmd_array #(
    parameter int WORDS = 2048,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [31:0]      wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [31:0]      rdata_o
);
    logic [31:0] mem [WORDS];

    // Storage powers up in the erased state.
    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '1;
    end

    always @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/flcmd_pgmbuf.sv
module flcmd_pgmbuf #(
    parameter int BUF_WORDS = 32,
    parameter int BIX_W     = 5
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [BIX_W-1:0] widx_i,
    input  logic [31:0]      wdata_i,
    input  logic [BIX_W-1:0] ridx_i,
    output logic [31:0]      rdata_o
);
    logic [31:0] slot [BUF_WORDS];

    always_ff @(posedge clk) begin
        if (we_i) slot[widx_i] <= wdata_i;
    end

    assign rdata_o = slot[ridx_i];
endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
#(
    parameter int IDX_W = 11,
    parameter int LEN_W = 11,
    parameter int BIX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  job_e             kind_i,
    input  logic [IDX_W-1:0] base_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [31:0]      buf_rdata_i,
    output logic             busy_o,
    output logic [BIX_W-1:0] buf_ridx_o,
    output logic             mem_we_o,
    output logic [IDX_W-1:0] mem_waddr_o,
    output logic [31:0]      mem_wdata_o
);
    logic             busy_q;
    job_e             kind_q;
    logic [IDX_W-1:0] addr_q;
    logic [LEN_W-1:0] left_q;
    logic [BIX_W-1:0] bidx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kind_q <= JOB_ERASE;
            addr_q <= '0;
            left_q <= '0;
            bidx_q <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            kind_q <= kind_i;
            addr_q <= base_i;
            left_q <= len_i;
            bidx_q <= '0;
        end else if (busy_q) begin
            addr_q <= addr_q + 1'b1;
            bidx_q <= bidx_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) busy_q <= 1'b0;
        end
    end

    assign busy_o      = busy_q;
    assign buf_ridx_o  = bidx_q;
    assign mem_we_o    = busy_q;
    assign mem_waddr_o = addr_q;
    assign mem_wdata_o = (kind_q == JOB_ERASE) ? 32'hFFFF_FFFF : buf_rdata_i;

    // A start while running would mean a bus write was accepted during busy.
    assert_start_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_q);

    assert_job_not_empty_R6: assert property (@(posedge clk) disable iff (rst)
        start_i |-> len_i != '0);

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && left_q > LEN_W'(1)) |=> busy_q);
endmodule

// File: rtl/flcmd_decode.sv
module flcmd_decode
    import flcmd_pkg::*;
#(
    parameter int WORDS       = 2048,
    parameter int BLOCK_WORDS = 1024,
    parameter int BUF_WORDS   = 32,
    parameter int ADDR_W      = 12,
    parameter int IDX_W       = 11,
    parameter int LEN_W       = 11,
    parameter int BIX_W       = 5,
    parameter int CNT_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              busy_i,
    output rd_mode_e          mode_o,
    output logic              in_seq_o,
    output logic [6:0]        status_o,
    output logic              err_o,
    output logic              buf_we_o,
    output logic [BIX_W-1:0]  buf_widx_o,
    output logic [31:0]       buf_wdata_o,
    output logic              job_start_o,
    output job_e              job_kind_o,
    output logic [IDX_W-1:0]  job_base_o,
    output logic [LEN_W-1:0]  job_len_o
);
    rd_mode_e          mode_q, nxt_mode;
    phase_e            phase_q, nxt_phase;
    logic [6:0]        stat_q;
    logic              err_q;
    logic [ADDR_W-1:0] target_q;
    logic [CNT_W-1:0]  cnt_q, rem_q;

    logic        fault, clr_stat, set_target, load_cnt, dec_rem;
    logic [15:0] op;
    logic [31:0] addr32, target32, n32, rel32, room32;

    assign op       = wdata_i[15:0];
    assign addr32   = 32'(addr_i);
    assign target32 = 32'(target_q);
    assign n32      = 32'(wdata_i[15:0]) + 32'd1;
    assign rel32    = addr32 - target32;
    assign room32   = 32'(WORDS) - addr32;

    always_comb begin
        nxt_mode    = mode_q;
        nxt_phase   = phase_q;
        fault       = 1'b0;
        clr_stat    = 1'b0;
        set_target  = 1'b0;
        load_cnt    = 1'b0;
        dec_rem     = 1'b0;
        buf_we_o    = 1'b0;
        job_start_o = 1'b0;
        job_kind_o  = JOB_ERASE;
        job_base_o  = IDX_W'(addr_i);
        job_len_o   = '0;
        if (wr_i && !busy_i) begin
            unique case (phase_q)
                PH_CMD: begin
                    if (!halves_match(wdata_i)) begin
                        fault = 1'b1;
                    end else begin
                        case (op)
                            OP_RD_STATUS: nxt_mode = RD_STATUS;
                            OP_RD_ARRAY:  nxt_mode = RD_ARRAY;
                            OP_RD_IDENT:  nxt_mode = RD_IDENT;
                            OP_ERASE_SETUP: nxt_phase = PH_ERASE_ADDR;
                            OP_PGM_SETUP: begin
                                set_target = 1'b1;
                                nxt_phase  = PH_PGM_COUNT;
                            end
                            OP_CLR_STATUS: begin
                                clr_stat = 1'b1;
                                nxt_mode = RD_ARRAY;
                            end
                            default: fault = 1'b1;
                        endcase
                    end
                end
                PH_ERASE_ADDR: begin
                    nxt_mode  = RD_STATUS;
                    nxt_phase = PH_CMD;
                    if (addr32 < 32'(WORDS)) begin
                        job_start_o = 1'b1;
                        job_len_o   = (room32 < 32'(BLOCK_WORDS)) ? LEN_W'(room32)
                                                                  : LEN_W'(BLOCK_WORDS);
                    end
                end
                PH_PGM_COUNT: begin
                    if (n32 > 32'(BUF_WORDS)) begin
                        fault = 1'b1;
                    end else begin
                        load_cnt  = 1'b1;
                        nxt_phase = PH_PGM_DATA;
                    end
                end
                PH_PGM_DATA: begin
                    if (rem_q == '0) begin
                        if (op == OP_PGM_CONFIRM) begin
                            nxt_mode  = RD_ARRAY;
                            nxt_phase = PH_CMD;
                            if (target32 + 32'(cnt_q) <= 32'(WORDS)) begin
                                job_start_o = 1'b1;
                                job_kind_o  = JOB_COPY;
                                job_base_o  = IDX_W'(target_q);
                                job_len_o   = LEN_W'(cnt_q);
                            end
                        end else begin
                            fault = 1'b1;
                        end
                    end else if (addr32 >= target32 && rel32 < 32'(BUF_WORDS)) begin
                        buf_we_o = 1'b1;
                        dec_rem  = 1'b1;
                    end else begin
                        fault = 1'b1;
                    end
                end
            endcase
            if (fault) begin
                nxt_mode  = RD_ARRAY;
                nxt_phase = PH_CMD;
            end
        end
    end

    assign buf_widx_o  = BIX_W'(rel32);
    assign buf_wdata_o = wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= RD_ARRAY;
            phase_q  <= PH_CMD;
            stat_q   <= '0;
            err_q    <= 1'b0;
            target_q <= '0;
            cnt_q    <= '0;
            rem_q    <= '0;
        end else begin
            mode_q  <= nxt_mode;
            phase_q <= nxt_phase;
            err_q   <= fault;
            if (fault)         stat_q[ST_ERR_BIT] <= 1'b1;
            else if (clr_stat) stat_q <= stat_q & ~ST_CLR_MASK;
            if (set_target) target_q <= addr_i;
            if (load_cnt) begin
                cnt_q <= CNT_W'(n32);
                rem_q <= CNT_W'(n32);
            end else if (dec_rem) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign mode_o   = mode_q;
    assign in_seq_o = (phase_q != PH_CMD);
    assign status_o = stat_q;
    assign err_o    = err_q;

    assert_fault_cleanup_R12: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (stat_q[ST_ERR_BIT] && phase_q == PH_CMD && mode_q == RD_ARRAY));

    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_i && wr_i) |=> ($stable(phase_q) && $stable(mode_q) && $stable(stat_q)));

    assert_count_in_buffer_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PGM_DATA) |-> (rem_q <= cnt_q && 32'(cnt_q) <= 32'(BUF_WORDS)));
endmodule

// File: rtl/dual_nor_cmd_ctrl.sv
module dual_nor_cmd_ctrl
    import flcmd_pkg::*;
#(
    parameter int  ARRAY_BYTES = 8192,
    parameter int  BLOCK_BYTES = 4096,
    parameter int  BUF_WORDS   = 32,
    localparam int ADDR_W      = $clog2(ARRAY_BYTES / 4) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              flash_err
);
    localparam int WORDS       = ARRAY_BYTES / 4;
    localparam int BLOCK_WORDS = BLOCK_BYTES / 4;
    localparam int IDX_W       = $clog2(WORDS);
    localparam int BIX_W       = $clog2(BUF_WORDS);
    localparam int CNT_W       = $clog2(BUF_WORDS + 1);
    localparam int MAX_JOB     = (BLOCK_WORDS > BUF_WORDS) ? BLOCK_WORDS : BUF_WORDS;
    localparam int LEN_W       = $clog2(MAX_JOB + 1);

    rd_mode_e         mode;
    logic             in_seq, seq_busy, job_start;
    job_e             job_kind;
    logic [6:0]       stat_low;
    logic [IDX_W-1:0] job_base, mem_waddr;
    logic [LEN_W-1:0] job_len;
    logic             buf_we, mem_we;
    logic [BIX_W-1:0] buf_widx, buf_ridx;
    logic [31:0]      buf_wdata, buf_rdata, mem_wdata, arr_rdata;
    logic [7:0]       status_byte;
    logic             status_view;

    flcmd_decode #(
        .WORDS(WORDS), .BLOCK_WORDS(BLOCK_WORDS), .BUF_WORDS(BUF_WORDS),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .BIX_W(BIX_W), .CNT_W(CNT_W)
    ) u_decode (
        .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .busy_i(seq_busy), .mode_o(mode), .in_seq_o(in_seq), .status_o(stat_low),
        .err_o(flash_err), .buf_we_o(buf_we), .buf_widx_o(buf_widx),
        .buf_wdata_o(buf_wdata), .job_start_o(job_start), .job_kind_o(job_kind),
        .job_base_o(job_base), .job_len_o(job_len)
    );

    flcmd_pgmbuf #(.BUF_WORDS(BUF_WORDS), .BIX_W(BIX_W)) u_pgmbuf (
        .clk(clk), .we_i(buf_we), .widx_i(buf_widx), .wdata_i(buf_wdata),
        .ridx_i(buf_ridx), .rdata_o(buf_rdata)
    );

    flcmd_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W), .BIX_W(BIX_W)) u_seq (
        .clk(clk), .rst(rst), .start_i(job_start), .kind_i(job_kind), .base_i(job_base),
        .len_i(job_len), .buf_rdata_i(buf_rdata), .busy_o(seq_busy), .buf_ridx_o(buf_ridx),
        .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
    );

    flcmd_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_array (
        .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
        .raddr_i(bus_addr[IDX_W-1:0]), .rdata_o(arr_rdata)
    );

    assign status_byte = {~seq_busy, stat_low};
    assign status_view = (mode == RD_STATUS) || in_seq || seq_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (status_view)                      bus_rdata <= status_word(status_byte);
            else if (mode == RD_IDENT)            bus_rdata <= '0;
            else if (32'(bus_addr) >= 32'(WORDS)) bus_rdata <= '1;
            else                                  bus_rdata <= arr_rdata;
        end
    end

    assert_status_replicated_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && status_view) |=>
        (bus_rdata[31:24] == 8'h00 && bus_rdata[15:8] == 8'h00 &&
         bus_rdata[23:16] == bus_rdata[7:0]));

    assert_ident_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !status_view && mode == RD_IDENT) |=> bus_rdata == 32'h0);

    assert_busy_reads_status_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && seq_busy) |=> (bus_rdata[7] == 1'b0 && bus_rdata[23] == 1'b0));
endmodule

// File: tb/test_dual_nor_cmd_ctrl.sv
`timescale 1ns/1ps
module test_dual_nor_cmd_ctrl;
    localparam int AB = 1024;
    localparam int BB = 64;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          flash_err;

    dual_nor_cmd_ctrl #(.ARRAY_BYTES(AB), .BLOCK_BYTES(BB), .BUF_WORDS(32)) i_dual_nor_cmd_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_err(flash_err)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;
    int   checks = 0;
    int   fails = 0;
    int   err_seen = 0;
    logic rd_pending = 1'b0;
    logic done = 1'b0;

    always @(posedge clk) rd_pending <= bus_rd;

    // Monitor: compares each returned read against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && flash_err) err_seen++;
        if (rd_pending) begin
            cur = sb_q.pop_front();
            checks++;
            if (bus_rdata !== cur.exp) begin
                fails++;
                $display("FAIL %s: actual %08h expected %08h", cur.tag, bus_rdata, cur.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        sb_q.push_back('{e, tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_err(input int e, input string tag);
        checks++;
        if (err_seen != e) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, err_seen, e);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2 / R5: reset state and plain array reads
        rd(0,   32'hFFFF_FFFF, "R2 erased word");
        rd(255, 32'hFFFF_FFFF, "R2 last word");
        rd(300, 32'hFFFF_FFFF, "R2 beyond array");
        wr(0, 32'h0070_0070);
        rd(0, 32'h0080_0080, "R1 R5 reset status");

        // R4: identifier and back to array
        wr(0, 32'h0090_0090);
        rd(5, 32'h0000_0000, "R4 ident reads zero");
        wr(0, 32'h00FF_00FF);
        rd(5, 32'hFFFF_FFFF, "R4 back to array");

        // R9 / R11 / R7: buffered program of four words at 8
        wr(8, 32'h00E8_00E8);
        rd(8, 32'h0080_0080, "R11 status after setup");
        wr(0, 32'h0000_0003);
        rd(0, 32'h0080_0080, "R11 status during data");
        for (int i = 0; i < 4; i++) wr(AW'(8 + i), 32'hA5A5_0000 + i);
        wr(8, 32'h00D0_00D0);
        rd(8, 32'h0000_0000, "R7 busy during copy");
        idle(6);
        for (int i = 0; i < 4; i++) rd(AW'(8 + i), 32'hA5A5_0000 + i, "R9 programmed word");
        rd(12, 32'hFFFF_FFFF, "R9 neighbour untouched");

        // program 248..255 for the clipped erase
        wr(248, 32'h00E8_00E8);
        wr(0, 32'h0000_0007);
        for (int i = 0; i < 8; i++) wr(AW'(248 + i), 32'h5A00_0000 + i);
        wr(248, 32'h00D0_00D0);
        idle(10);
        rd(255, 32'h5A00_0007, "R9 top word programmed");

        // R6 / R7 / R8: erase 16 words from 9, bus command during busy
        wr(0, 32'h0020_0020);
        wr(9, 32'h0000_0009);
        wr(0, 32'h0090_0090);
        idle(14);
        rd(0, 32'h0000_0000, "R7 busy on last erase clock");
        rd(0, 32'h0080_0080, "R8 R6 status mode and ready");
        wr(0, 32'h00FF_00FF);
        rd(8,  32'hA5A5_0000, "R6 word below start kept");
        rd(9,  32'hFFFF_FFFF, "R6 first erased word");
        rd(11, 32'hFFFF_FFFF, "R6 erased word");

        // R6: erase clipped at the array end
        wr(0, 32'h0020_0020);
        wr(252, 32'h0);
        idle(6);
        wr(0, 32'h00FF_00FF);
        rd(251, 32'h5A00_0003, "R6 word before clipped erase kept");
        rd(252, 32'hFFFF_FFFF, "R6 clipped erase start");
        rd(255, 32'hFFFF_FFFF, "R6 clipped erase end");

        // R10: program running past the end is dropped
        wr(250, 32'h00E8_00E8);
        wr(0, 32'h0000_0007);
        for (int i = 0; i < 8; i++) wr(AW'(250 + i), 32'h1111_0000 + i);
        wr(250, 32'h00D0_00D0);
        idle(3);
        rd(250, 32'h5A00_0002, "R10 array unchanged");
        rd(253, 32'hFFFF_FFFF, "R10 array unchanged high");
        idle(1);
        check_err(0, "R10 no error");

        // R3 / R12 / R13
        wr(0, 32'h0070_0050);
        idle(1);
        check_err(1, "R3 halves mismatch error");
        rd(8, 32'hA5A5_0000, "R12 array mode after error");
        wr(0, 32'h0070_0070);
        rd(0, 32'h0090_0090, "R12 status bit4 set");
        wr(0, 32'h0050_0050);
        rd(8, 32'hA5A5_0000, "R13 array mode after clear");
        wr(0, 32'h0070_0070);
        rd(0, 32'h0080_0080, "R13 bit4 cleared");

        wr(0, 32'h00AB_00AB);
        idle(1);
        check_err(2, "R12 unknown code");
        wr(0, 32'h00D0_00D0);
        idle(1);
        check_err(3, "R12 confirm as first command");

        wr(40, 32'h00E8_00E8);
        wr(0, 32'h0000_0020);
        idle(1);
        check_err(4, "R12 count overflow");
        rd(8, 32'hA5A5_0000, "R12 array mode after overflow");
        wr(0, 32'h0050_0050);

        // R9: largest buffer, 32 words
        wr(40, 32'h00E8_00E8);
        wr(0, 32'h0000_001F);
        rd(0, 32'h0080_0080, "R9 32 words accepted");
        for (int i = 0; i < 32; i++) wr(AW'(40 + i), 32'hC000_0000 + i);
        wr(40, 32'h00D0_00D0);
        idle(36);
        rd(40, 32'hC000_0000, "R9 full buffer first");
        rd(71, 32'hC000_001F, "R9 full buffer last");

        // R12: missing confirm
        wr(100, 32'h00E8_00E8);
        wr(0, 32'h0000_0000);
        wr(100, 32'h7777_7777);
        wr(100, 32'h00FF_00FF);
        idle(1);
        check_err(5, "R12 missing confirm");
        rd(100, 32'hFFFF_FFFF, "R12 no copy without confirm");

        // R12: data offset below target
        wr(100, 32'h00E8_00E8);
        wr(0, 32'h0000_0001);
        wr(99, 32'h1234_5678);
        idle(1);
        check_err(6, "R12 data outside window");
        rd(99, 32'hFFFF_FFFF, "R12 array mode after window error");
        wr(0, 32'h0070_0070);
        rd(0, 32'h0090_0090, "R12 status after window error");

        idle(2);
        done = 1'b1;
        report();
    end
endmodule